// File: doc/BRIEF.md
# Load/Store Unit with Atomic Fetch-and-Add

This unit is the memory-access stage of a 64-bit register machine. One request at a time, it takes an operation, an access size, a base register value, a signed 16-bit displacement, a source register value and a 32-bit immediate. It forms the effective address and runs the access on a single request/ready memory port with byte enables. The supported operations are a register load, a register store, an immediate store and an atomic fetch-and-add. Load results go back toward the register file on `rd_data`, together with a one-cycle `done` pulse.

The fetch-and-add is a locked read-modify-write. The unit reads the addressed word and adds the source register to it, keeping only the access width. It then writes the sum back to the same address. `mem_lock` stays high from the read request until the write is accepted, so the memory side can keep every other agent out for the whole sequence. While an access is in flight, `busy` is high and new requests are not taken.

The memory is little-endian. The data bus is 64 bits wide and its byte lanes are selected by the low three address bits. Accesses are expected to be naturally aligned.

Top module: `ldst_amo_unit`

## Requirements
- R1: The memory address of every access equals `req_base` plus `req_off` sign-extended to 64 bits, and it is presented unchanged on `mem_addr`.
- R2: A load (`req_op` = 0) returns the addressed bytes zero-extended to 64 bits on `rd_data`. `done` is high for one cycle, starting with the clock edge after the edge that accepted the read handshake.
- R3: A register store (`req_op` = 1) writes the low 1, 2, 4 or 8 bytes of `req_src` to the effective address and leaves every other byte of memory unchanged.
- R4: An immediate store (`req_op` = 2) writes `req_imm`. For byte, halfword and word sizes the immediate is truncated. For the doubleword size it is sign-extended from bit 31.
- R5: Size encoding is 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. `mem_be` equals (2^bytes − 1) shifted left by `mem_addr[2:0]`, kept to 8 bits. Write data sits in the same byte lanes, and read data is taken from them.
- R6: A fetch-and-add (`req_op` = 3) reads the word or doubleword, adds the same-width low part of `req_src`, and writes the sum to the same address. Any carry out of the access width is discarded.
- R7: During a fetch-and-add, `mem_lock` is high on both the read and the write request with no gap between them, and it falls only after the write handshake. `mem_lock` is never high for the other operations.
- R8: `busy` is high from the cycle after a request is accepted until the access completes. Requests presented while `busy` is high are ignored and cause no memory traffic.
- R9: A fetch-and-add with byte or halfword size is not accepted. It produces no memory request, no `done` pulse and no change to memory.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we`, `mem_be` and `mem_lock` hold their values.
- R11: After reset, `busy`, `done`, `mem_req` and `mem_lock` are low and `rd_data` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 load, 1 register store, 2 immediate store, 3 fetch-and-add |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_base | input | 64 | Base register value |
| req_off | input | OFF_W (16) | Signed displacement |
| req_src | input | 64 | Source register value (store data or addend) |
| req_imm | input | 32 | Immediate for immediate stores |
| busy | output | 1 | Access in flight |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 64 | Zero-extended load result |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Locked read-modify-write in progress |
| mem_addr | output | ADDR_W (64) | Byte address |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Write data, lane-aligned |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 64 | Read data, valid with mem_ready |

## Verification
Loads are tried at every size, at every byte-lane position including the top lane, with positive and negative displacements. This separates errors in lane selection, zero extension and address sign extension. Stores of each kind are read back whole with a doubleword load, so any byte written outside the enabled lanes, or any wrong immediate extension, shows up. Fetch-and-add runs at both widths, including a word sum that overflows and a doubleword sum that carries across bytes, which shows whether carries are confined to the access width. Memory wait states from zero to three cycles, a request offered while busy, and a narrow fetch-and-add show that the port holds steady, that the lock spans both phases and that illegal or overlapping requests are refused.

// File: rtl/ldst_pkg.sv
`timescale 1ns/1ps
package ldst_pkg;
  localparam int XLEN   = 64;
  localparam int LANES  = XLEN / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    OP_LOAD      = 2'd0,
    OP_STORE_REG = 2'd1,
    OP_STORE_IMM = 2'd2,
    OP_FETCH_ADD = 2'd3
  } ldst_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } ldst_size_e;

  // byte-lane mask for an access of the given size starting at lane 0
  function automatic logic [LANES-1:0] size_lanes(ldst_size_e sz);
    logic [LANES-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++)
      if (i < (1 << sz)) m[i] = 1'b1;
    return m;
  endfunction

  // keep the low bits of the access width, clear the rest
  function automatic logic [XLEN-1:0] keep_low(logic [XLEN-1:0] v, ldst_size_e sz);
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < XLEN; i++)
      if (i < (8 << sz)) m[i] = 1'b1;
    return v & m;
  endfunction

  function automatic logic [XLEN-1:0] to_lanes(logic [XLEN-1:0] v, logic [LANE_W-1:0] lane);
    return v << {lane, 3'b000};
  endfunction

  function automatic logic [XLEN-1:0] from_lanes(logic [XLEN-1:0] v, logic [LANE_W-1:0] lane);
    return v >> {lane, 3'b000};
  endfunction

  function automatic logic [XLEN-1:0] imm_extend(logic [31:0] imm, ldst_size_e sz);
    return (sz == SZ_DWORD) ? {{(XLEN-32){imm[31]}}, imm} : {{(XLEN-32){1'b0}}, imm};
  endfunction
endpackage

// File: rtl/ldst_agen.sv
`timescale 1ns/1ps
module ldst_agen
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16
) (
  input  logic [XLEN-1:0]   base,
  input  logic [OFF_W-1:0]  off,
  input  ldst_size_e        size,
  output logic [ADDR_W-1:0] addr,
  output logic [LANE_W-1:0] lane,
  output logic [LANES-1:0]  be
);
  localparam int EXT_W = XLEN - OFF_W;

  logic [XLEN-1:0] eff;

  assign eff  = base + {{EXT_W{off[OFF_W-1]}}, off};
  assign addr = eff[ADDR_W-1:0];
  assign lane = eff[LANE_W-1:0];
  assign be   = size_lanes(size) << lane;
endmodule

// File: rtl/ldst_dpath.sv
`timescale 1ns/1ps
module ldst_dpath
  import ldst_pkg::*;
(
  input  ldst_op_e          op,
  input  ldst_size_e        size,
  input  logic [LANE_W-1:0] lane,
  input  logic [XLEN-1:0]   src,
  input  logic [31:0]       imm,
  input  logic [XLEN-1:0]   old_val,
  input  logic [XLEN-1:0]   rdata,
  output logic [XLEN-1:0]   load_val,
  output logic [XLEN-1:0]   wdata
);
  logic [XLEN-1:0] sum_val;
  logic [XLEN-1:0] store_val;

  assign load_val = keep_low(from_lanes(rdata, lane), size);
  assign sum_val  = keep_low(old_val + keep_low(src, size), size);

  always_comb begin
    case (op)
      OP_STORE_REG: store_val = src;
      OP_STORE_IMM: store_val = imm_extend(imm, size);
      OP_FETCH_ADD: store_val = sum_val;
      default:      store_val = '0;
    endcase
  end

  assign wdata = to_lanes(keep_low(store_val, size), lane);
endmodule

// File: rtl/ldst_fsm.sv
`timescale 1ns/1ps
module ldst_fsm
  import ldst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  ldst_op_e   req_op,
  input  ldst_size_e req_size,
  input  logic       mem_ready,
  output logic       accept,
  output logic       busy,
  output logic       mem_req,
  output logic       mem_we,
  output logic       mem_lock,
  output logic       amo_rd_fire,
  output logic       load_fire,
  output logic       finish
);
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_STORE, S_AMO_RD, S_AMO_WR
  } st_e;

  st_e state, state_nx;
  logic legal;

  assign legal  = !(req_op == OP_FETCH_ADD && (req_size == SZ_BYTE || req_size == SZ_HALF));
  assign accept = (state == S_IDLE) && req_valid && legal;

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE: if (accept) begin
        case (req_op)
          OP_LOAD:      state_nx = S_LOAD;
          OP_FETCH_ADD: state_nx = S_AMO_RD;
          default:      state_nx = S_STORE;
        endcase
      end
      S_LOAD, S_STORE, S_AMO_WR: if (mem_ready) state_nx = S_IDLE;
      S_AMO_RD: if (mem_ready) state_nx = S_AMO_WR;
      default: state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= state_nx;
  end

  assign busy        = (state != S_IDLE);
  assign mem_req     = busy;
  assign mem_we      = (state == S_STORE) || (state == S_AMO_WR);
  assign mem_lock    = (state == S_AMO_RD) || (state == S_AMO_WR);
  assign amo_rd_fire = (state == S_AMO_RD) && mem_ready;
  assign load_fire   = (state == S_LOAD) && mem_ready;
  assign finish      = mem_ready && ((state == S_LOAD) || (state == S_STORE) || (state == S_AMO_WR));
endmodule

// File: rtl/ldst_amo_unit.sv
`timescale 1ns/1ps
module ldst_amo_unit
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic [XLEN-1:0]   req_base,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [XLEN-1:0]   req_src,
  input  logic [31:0]       req_imm,
  output logic              busy,
  output logic              done,
  output logic [XLEN-1:0]   rd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_ready,
  input  logic [XLEN-1:0]   mem_rdata
);
  // named internal events, observed by the bound checker
  logic accept_evt;
  logic amo_rd_evt;
  logic load_evt;
  logic finish_evt;

  ldst_op_e          r_op;
  ldst_size_e        r_size;
  logic [XLEN-1:0]   r_base;
  logic [OFF_W-1:0]  r_off;
  logic [XLEN-1:0]   r_src;
  logic [31:0]       r_imm;
  logic [XLEN-1:0]   r_old;
  logic [LANE_W-1:0] lane;
  logic [XLEN-1:0]   load_val;

  ldst_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (ldst_op_e'(req_op)),
    .req_size   (ldst_size_e'(req_size)),
    .mem_ready  (mem_ready),
    .accept     (accept_evt),
    .busy       (busy),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_lock   (mem_lock),
    .amo_rd_fire(amo_rd_evt),
    .load_fire  (load_evt),
    .finish     (finish_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_op   <= OP_LOAD;
      r_size <= SZ_BYTE;
      r_base <= '0;
      r_off  <= '0;
      r_src  <= '0;
      r_imm  <= '0;
    end else if (accept_evt) begin
      r_op   <= ldst_op_e'(req_op);
      r_size <= ldst_size_e'(req_size);
      r_base <= req_base;
      r_off  <= req_off;
      r_src  <= req_src;
      r_imm  <= req_imm;
    end
  end

  ldst_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
    .base(r_base),
    .off (r_off),
    .size(r_size),
    .addr(mem_addr),
    .lane(lane),
    .be  (mem_be)
  );

  ldst_dpath u_dpath (
    .op      (r_op),
    .size    (r_size),
    .lane    (lane),
    .src     (r_src),
    .imm     (r_imm),
    .old_val (r_old),
    .rdata   (mem_rdata),
    .load_val(load_val),
    .wdata   (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_old   <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= finish_evt;
      if (amo_rd_evt) r_old   <= load_val;
      if (load_evt)   rd_data <= load_val;
    end
  end
endmodule

// File: rtl/ldst_amo_checker.sv
`timescale 1ns/1ps
module ldst_amo_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_lock,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_be,
  input logic              accept_evt,
  input logic              amo_rd_evt
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_be) && $stable(mem_lock));

  assert_be_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 ||
                 $countones(mem_be) == 4 || $countones(mem_be) == 8));

  assert_lock_to_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    amo_rd_evt |=> mem_req && mem_we && mem_lock && $stable(mem_addr));

  assert_lock_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> $past(mem_we && mem_ready));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !mem_lock);

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy);

  assert_done_after_hs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(mem_req && mem_ready));
endmodule

bind ldst_amo_unit ldst_amo_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_lock  (mem_lock),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .accept_evt(accept_evt),
  .amo_rd_evt(amo_rd_evt)
);

// File: tb/ldst_amo_unit_tb.sv
`timescale 1ns/1ps
module ldst_amo_unit_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_base = '0;
  logic [15:0] req_off = '0;
  logic [63:0] req_src = '0;
  logic [31:0] req_imm = '0;
  wire         busy, done, mem_req, mem_we, mem_lock;
  wire  [63:0] rd_data, mem_addr, mem_wdata;
  wire  [7:0]  mem_be;
  logic        mem_ready = 1'b0;
  logic [63:0] mem_rdata = '0;

  ldst_amo_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_size(req_size), .req_base(req_base), .req_off(req_off),
    .req_src(req_src), .req_imm(req_imm), .busy(busy), .done(done),
    .rd_data(rd_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int n_run = 0;
  int n_fail = 0;

  // byte-addressed memory model with programmable wait states
  logic [7:0]  mem [256];
  int          mem_wait = 0;
  int          wcnt = 0;
  int          tx_n = 0;
  int          lock_gap = 0;
  int          hold_err = 0;
  bit          in_amo = 1'b0;
  logic [63:0] hold_addr = '0;
  logic        tx_we [4];
  logic        tx_lock [4];
  logic [63:0] tx_addr [4];
  logic [7:0]  tx_be [4];

  always @(negedge clk) begin
    if (rst_n) begin
      if (in_amo && mem_req && !mem_lock) lock_gap++;
      if (mem_ready) begin
        mem_ready = 1'b0;
        wcnt = 0;
      end else if (mem_req) begin
        if (wcnt == 0) hold_addr = mem_addr;
        else if (mem_addr != hold_addr) hold_err++;
        if (wcnt >= mem_wait) begin
          mem_ready = 1'b1;
          for (int k = 0; k < 8; k++) mem_rdata[8*k +: 8] = mem[{mem_addr[7:3], 3'(k)}];
          if (tx_n < 4) begin
            tx_we[tx_n] = mem_we;
            tx_lock[tx_n] = mem_lock;
            tx_addr[tx_n] = mem_addr;
            tx_be[tx_n] = mem_be;
          end
          tx_n++;
          if (mem_we)
            for (int k = 0; k < 8; k++)
              if (mem_be[k]) mem[{mem_addr[7:3], 3'(k)}] = mem_wdata[8*k +: 8];
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tg(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; default: return "R11";
    endcase
  endfunction

  function automatic logic [7:0] exp_be(input logic [1:0] sz, input logic [2:0] low);
    logic [7:0] m;
    case (sz)
      2'd0: m = 8'h01;
      2'd1: m = 8'h03;
      2'd2: m = 8'h0F;
      default: m = 8'hFF;
    endcase
    return m << low;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [1:0] sz,
                        input logic [63:0] base, input logic [15:0] off,
                        input logic [63:0] src, input logic [31:0] imm,
                        input int wt, output bit got);
    @(negedge clk);
    mem_wait = wt; tx_n = 0; lock_gap = 0; in_amo = (op == 2'd3);
    req_op = op; req_size = sz; req_base = base; req_off = off;
    req_src = src; req_imm = imm; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (done) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  sz;
    logic [15:0] base;
    logic [15:0] off;
    logic [63:0] src;
    logic [31:0] imm;
    logic [63:0] exp;
    logic        chk;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 25;
  // memory starts with every byte equal to its own address
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd0, 16'h0010, 16'h0005, 64'h0, 32'h0, 64'h15, 1'b1, 4'd2},
    '{2'd0, 2'd1, 16'h0040, 16'hFFFE, 64'h0, 32'h0, 64'h3F3E, 1'b1, 4'd2},
    '{2'd0, 2'd2, 16'h0020, 16'h0004, 64'h0, 32'h0, 64'h27262524, 1'b1, 4'd2},
    '{2'd0, 2'd3, 16'h0080, 16'h0008, 64'h0, 32'h0, 64'h8F8E8D8C8B8A8988, 1'b1, 4'd2},
    '{2'd0, 2'd0, 16'h00F0, 16'h000F, 64'h0, 32'h0, 64'hFF, 1'b1, 4'd2},
    '{2'd1, 2'd1, 16'h0050, 16'h0002, 64'hAAAABBBBCCCCDDEE, 32'h0, 64'h0, 1'b0, 4'd3},
    '{2'd0, 2'd3, 16'h0050, 16'h0000, 64'h0, 32'h0, 64'h57565554DDEE5150, 1'b1, 4'd3},
    '{2'd2, 2'd2, 16'h0060, 16'h0000, 64'h0, 32'h80000001, 64'h0, 1'b0, 4'd4},
    '{2'd0, 2'd3, 16'h0060, 16'h0000, 64'h0, 32'h0, 64'h6766656480000001, 1'b1, 4'd4},
    '{2'd2, 2'd3, 16'h0068, 16'h0000, 64'h0, 32'hFFFFFFF0, 64'h0, 1'b0, 4'd4},
    '{2'd0, 2'd3, 16'h0068, 16'h0000, 64'h0, 32'h0, 64'hFFFFFFFFFFFFFFF0, 1'b1, 4'd4},
    '{2'd1, 2'd0, 16'h0070, 16'h0001, 64'h123456789ABCDE5A, 32'h0, 64'h0, 1'b0, 4'd3},
    '{2'd0, 2'd2, 16'h0070, 16'h0000, 64'h0, 32'h0, 64'h73725A70, 1'b1, 4'd3},
    '{2'd3, 2'd2, 16'h0020, 16'h0004, 64'h0000000100000010, 32'h0, 64'h0, 1'b0, 4'd6},
    '{2'd0, 2'd3, 16'h0020, 16'h0000, 64'h0, 32'h0, 64'h2726253423222120, 1'b1, 4'd6},
    '{2'd3, 2'd2, 16'h0030, 16'h0000, 64'h00000000FFFFFFFF, 32'h0, 64'h0, 1'b0, 4'd6},
    '{2'd0, 2'd3, 16'h0030, 16'h0000, 64'h0, 32'h0, 64'h373635343332312F, 1'b1, 4'd6},
    '{2'd3, 2'd3, 16'h0090, 16'hFFF8, 64'h78, 32'h0, 64'h0, 1'b0, 4'd6},
    '{2'd0, 2'd3, 16'h0088, 16'h0000, 64'h0, 32'h0, 64'h8F8E8D8C8B8A8A00, 1'b1, 4'd6},
    '{2'd3, 2'd0, 16'h0090, 16'h0000, 64'h5, 32'h0, 64'h0, 1'b0, 4'd9},
    '{2'd0, 2'd0, 16'h0090, 16'h0000, 64'h0, 32'h0, 64'h90, 1'b1, 4'd9},
    '{2'd1, 2'd3, 16'h0078, 16'h0000, 64'h0123456789ABCDEF, 32'h0, 64'h0, 1'b0, 4'd3},
    '{2'd0, 2'd3, 16'h0078, 16'h0000, 64'h0, 32'h0, 64'h0123456789ABCDEF, 1'b1, 4'd3},
    '{2'd2, 2'd0, 16'h0099, 16'h0000, 64'h0, 32'h12345678, 64'h0, 1'b0, 4'd4},
    '{2'd0, 2'd1, 16'h0098, 16'h0000, 64'h0, 32'h0, 64'h7898, 1'b1, 4'd4}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: actual %0s expected %0s", "hung", "finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit got;
    for (int a = 0; a < 256; a++) mem[a] = 8'(a);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: idle after reset
    check(!busy && !done, "R11", "busy/done after reset", {62'd0, busy, done}, 64'd0);
    check(!mem_req && !mem_lock, "R11", "mem_req/mem_lock after reset",
          {62'd0, mem_req, mem_lock}, 64'd0);
    check(rd_data == 64'd0, "R11", "rd_data after reset", rd_data, 64'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int exp_tx;
      logic [63:0] ea;
      v = VEC[i];
      ea = {48'd0, v.base} + {{48{v.off[15]}}, v.off};
      exp_tx = (v.op == 2'd3) ? ((v.sz >= 2'd2) ? 2 : 0) : 1;
      run_op(v.op, v.sz, {48'd0, v.base}, v.off, v.src, v.imm, i % 4, got);
      check(tx_n == exp_tx, (exp_tx == 0) ? "R9" : "R8", "transaction count",
            64'(tx_n), 64'(exp_tx));
      if (exp_tx == 0) begin
        check(!got, "R9", "done for refused request", {63'd0, got}, 64'd0);
      end else begin
        check(got, "R2", "done pulse seen", {63'd0, got}, 64'd1);
        check(tx_addr[0] == ea, "R1", "effective address", tx_addr[0], ea);
        check(tx_be[0] == exp_be(v.sz, ea[2:0]), "R5", "byte enables",
              {56'd0, tx_be[0]}, {56'd0, exp_be(v.sz, ea[2:0])});
        if (exp_tx == 2) begin
          check(tx_lock[0] && tx_lock[1] && !tx_we[0] && tx_we[1] && lock_gap == 0,
                "R7", "locked read then write",
                {60'd0, tx_lock[0], tx_lock[1], tx_we[0], tx_we[1]}, 64'hD);
          check(tx_addr[1] == ea, "R6", "write-back address", tx_addr[1], ea);
        end else begin
          check(!tx_lock[0], "R7", "lock on plain access", {63'd0, tx_lock[0]}, 64'd0);
        end
      end
      if (v.chk) check(rd_data == v.exp, tg(int'(v.rq)), "load result", rd_data, v.exp);
    end

    // R8: a request offered while busy is dropped
    @(negedge clk);
    mem_wait = 3; tx_n = 0; lock_gap = 0; in_amo = 1'b1;
    req_op = 2'd3; req_size = 2'd2; req_base = 64'h40; req_off = 16'h0;
    req_src = 64'h1; req_imm = 32'h0; req_valid = 1'b1;
    @(negedge clk);
    check(busy, "R8", "busy after accept", {63'd0, busy}, 64'd1);
    req_op = 2'd2; req_size = 2'd0; req_base = 64'h98; req_imm = 32'hEE;
    repeat (2) @(negedge clk);
    check(busy, "R8", "still busy during locked access", {63'd0, busy}, 64'd1);
    req_valid = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (done) break;
      @(negedge clk);
    end
    check(tx_n == 2 && lock_gap == 0, "R8", "only the locked pair ran",
          64'(tx_n), 64'd2);
    run_op(2'd0, 2'd0, 64'h98, 16'h0, 64'h0, 32'h0, 0, got);
    check(rd_data == 64'h98, "R8", "byte behind refused store", rd_data, 64'h98);
    run_op(2'd0, 2'd2, 64'h40, 16'h0, 64'h0, 32'h0, 1, got);
    check(rd_data == 64'h43424141, "R6", "sum after busy test", rd_data, 64'h43424141);

    check(hold_err == 0, "R10", "address held during wait states", 64'(hold_err), 64'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule